// File: doc/BRIEF.md
# Start-Up Image Loader with Glitch-Free Processor Clock Switch

This block runs the chip's power-up sequence. From reset it owns a simple memory-write bus while the processor is held in reset. It fetches a fixed-size program image one word at a time from a request/response read port. Each word is written to consecutive word addresses in system memory, starting at a configured base. When the last word has been written, the block hands the bus back and lets the processor out of reset. If the source reports an error, or goes silent for too long, the sequence stops: the processor stays in reset and an error flag is raised.

While the image is loading, the processor runs from the reference oscillator. Later, software can ask for the faster PLL-derived clock, and can also ask to return to the reference. The selection passes through two cross-coupled enable chains. Each chain runs on the falling edge of its own clock, so the processor clock never shows a shortened high or low phase. A select write that arrives while a switch is still in progress is dropped.

Top module: `boot_seq`

## Requirements
- R1: After reset, `bus_own`=1, `cpu_rst_n`=0, `load_done`=0, `load_err`=0, `clk_busy`=0, `clk_on_pll`=0, and `cpu_clk` follows `clk_ref`.
- R2: `src_req` is high only while the image is loading. Each accepted response (`src_ack`=1, `src_err`=0) yields exactly one `mem_we` pulse in the following cycle. That write carries `mem_addr` = `MEM_BASE` + word index and `mem_wdata` = the response data. Word indices run 0, 1, 2 … in order.
- R3: `src_addr` holds the index of the word being requested until its response arrives. A gap of up to `TIMEOUT`-1 cycles before a response causes no error.
- R4: In the cycle after the write of word `IMG_WORDS`-1, `bus_own` falls and `cpu_rst_n` and `load_done` rise. They keep those values until the next reset, and no further writes occur.
- R5: A response with `src_err`=1 stops the load. `load_err` rises and stays high until reset, `cpu_rst_n` stays 0, `bus_own` stays 1, and no further request or write is made.
- R6: If `TIMEOUT` consecutive loading cycles pass without a response, the block enters the same stopped state as R5. After `TIMEOUT`-1 such cycles, `load_err` is still 0.
- R7: A `clk_sel_wr` pulse with `clk_sel_pll`=1 while `clk_busy`=0 raises `clk_busy` in the next cycle. When the switch completes, `clk_busy` falls, `clk_on_pll` is 1 and `cpu_clk` follows `pll_clk`.
- R8: A `clk_sel_wr` pulse while `clk_busy`=1 has no effect: the pending selection and the final clock are unchanged.
- R9: At no time are both clock enables active. No `cpu_clk` high or low phase is shorter than the shorter half period of the two input clocks.
- R10: Writing `clk_sel_pll`=0 when idle on the PLL clock returns `cpu_clk` to `clk_ref`, and `clk_on_pll` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference oscillator; clocks the loader and the select register |
| pll_clk | input | 1 | Fast PLL-derived clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | output | 1 | Read request to the image source |
| src_addr | output | clog2(IMG_WORDS) | Word index being requested |
| src_ack | input | 1 | Response valid for the current request |
| src_err | input | 1 | Response is an error (qualified by src_ack) |
| src_data | input | DATA_W | Response data word |
| bus_own | output | 1 | Loader owns the memory bus |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| cpu_rst_n | output | 1 | Processor reset, active low |
| load_done | output | 1 | Image loaded and processor released |
| load_err | output | 1 | Load stopped on error or timeout |
| clk_sel_wr | input | 1 | Clock-select write strobe (reference domain) |
| clk_sel_pll | input | 1 | Selected source: 1 = PLL, 0 = reference |
| clk_busy | output | 1 | Clock switch in progress |
| clk_on_pll | output | 1 | Processor clock is running from the PLL |
| cpu_clk | output | 1 | Processor clock |

## Verification
The properties assume the following about the inputs. `src_ack` and `src_err` are driven only while `src_req` is high. `clk_sel_wr` and `clk_sel_pll` change only on the reference clock. Reset is deasserted away from edges of either clock. The bench meets these assumptions in four ways. Its source model answers only after it has seen a request, and changes its outputs on the falling reference edge. It drives select writes on that same edge. It releases reset one nanosecond after a rising edge. It runs the clock-switch tests only after the last reset, so no enable is ever cleared in the middle of a phase.

// File: rtl/boot_pkg.sv
package boot_pkg;
  typedef enum logic [2:0] {
    LD_IDLE  = 3'd0,
    LD_COPY  = 3'd1,
    LD_FLUSH = 3'd2,
    LD_RUN   = 3'd3,
    LD_FAIL  = 3'd4
  } ld_state_e;
endpackage

// File: rtl/boot_gate_chain.sv
// Enable chain clocked on the falling edge of its own clock.
module boot_gate_chain #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          stg_q[g] <= RST_VAL;
        end else begin
          if (g == 0) stg_q[g] <= d_i;
          else        stg_q[g] <= stg_q[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/boot_copy_fsm.sv
module boot_copy_fsm
  import boot_pkg::*;
#(
  parameter int              IMG_WORDS = 6144,
  parameter int              DATA_W    = 32,
  parameter int              ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] MEM_BASE = '0,
  parameter int              TIMEOUT   = 1024
) (
  input  logic                          clk,
  input  logic                          rst_n,
  output logic                          src_req,
  output logic [$clog2(IMG_WORDS)-1:0]  src_addr,
  input  logic                          src_ack,
  input  logic                          src_err,
  input  logic [DATA_W-1:0]             src_data,
  output logic                          mem_we,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [DATA_W-1:0]             mem_wdata,
  output logic                          run,
  output logic                          fail
);
  localparam int IDX_W = $clog2(IMG_WORDS);
  localparam int TMO_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(IMG_WORDS - 1);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TIMEOUT - 1);

  ld_state_e          state_q, state_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [TMO_W-1:0]   wait_q, wait_d;
  logic               we_q, we_d;
  logic               cap_en;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  data_q;
  logic               run_q, fail_q;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    wait_d  = wait_q;
    we_d    = 1'b0;
    cap_en  = 1'b0;
    unique case (state_q)
      LD_IDLE: begin
        state_d = LD_COPY;
        wait_d  = '0;
      end
      LD_COPY: begin
        if (src_ack) begin
          wait_d = '0;
          if (src_err) begin
            state_d = LD_FAIL;
          end else begin
            we_d   = 1'b1;
            cap_en = 1'b1;
            if (idx_q == LAST_IDX) state_d = LD_FLUSH;
            else                   idx_d   = idx_q + 1'b1;
          end
        end else if (wait_q == TMO_LAST) begin
          state_d = LD_FAIL;
        end else begin
          wait_d = wait_q + 1'b1;
        end
      end
      LD_FLUSH: state_d = LD_RUN;
      LD_RUN:   state_d = LD_RUN;
      LD_FAIL:  state_d = LD_FAIL;
      default:  state_d = LD_FAIL;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LD_IDLE;
      idx_q   <= '0;
      wait_q  <= '0;
      we_q    <= 1'b0;
      run_q   <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      wait_q  <= wait_d;
      we_q    <= we_d;
      run_q   <= (state_d == LD_RUN);
      fail_q  <= (state_d == LD_FAIL);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (cap_en) begin
      addr_q <= MEM_BASE + ADDR_W'(idx_q);
      data_q <= src_data;
    end
  end

  assign src_req   = (state_q == LD_COPY);
  assign src_addr  = idx_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;
  assign run       = run_q;
  assign fail      = fail_q;
endmodule

// File: rtl/boot_clk_switch.sv
module boot_clk_switch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_ref,
  input  logic pll_clk,
  input  logic rst_n,
  input  logic sel_wr,
  input  logic sel_pll,
  output logic busy,
  output logic on_pll,
  output logic cpu_clk,
  output logic sel_q,
  output logic en_ref,
  output logic en_pll
);
  logic [SYNC_STAGES-1:0] pll_seen_q;
  logic                   sel_en;
  logic                   pll_seen;

  assign sel_en = sel_wr & ~busy;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n)      sel_q <= 1'b0;
    else if (sel_en) sel_q <= sel_pll;
  end

  boot_gate_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ref_chain (
    .clk_i  (clk_ref),
    .rst_ni (rst_n),
    .d_i    (~sel_q & ~en_pll),
    .q_o    (en_ref)
  );

  boot_gate_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pll_chain (
    .clk_i  (pll_clk),
    .rst_ni (rst_n),
    .d_i    (sel_q & ~en_ref),
    .q_o    (en_pll)
  );

  // PLL-side enable brought back into the reference domain
  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) pll_seen_q <= '0;
    else        pll_seen_q <= {pll_seen_q[SYNC_STAGES-2:0], en_pll};
  end
  assign pll_seen = pll_seen_q[SYNC_STAGES-1];

  assign busy    = (sel_q != pll_seen) | (~sel_q & ~en_ref);
  assign on_pll  = pll_seen;
  assign cpu_clk = (clk_ref & en_ref) | (pll_clk & en_pll);
endmodule

// File: rtl/boot_seq.sv
module boot_seq #(
  parameter int                DATA_W      = 32,
  parameter int                ADDR_W      = 32,
  parameter int                IMG_WORDS   = 6144,
  parameter logic [ADDR_W-1:0] MEM_BASE    = '0,
  parameter int                TIMEOUT     = 1024,
  parameter int                SYNC_STAGES = 2
) (
  input  logic                         clk_ref,
  input  logic                         pll_clk,
  input  logic                         rst_n,
  output logic                         src_req,
  output logic [$clog2(IMG_WORDS)-1:0] src_addr,
  input  logic                         src_ack,
  input  logic                         src_err,
  input  logic [DATA_W-1:0]            src_data,
  output logic                         bus_own,
  output logic                         mem_we,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [DATA_W-1:0]            mem_wdata,
  output logic                         cpu_rst_n,
  output logic                         load_done,
  output logic                         load_err,
  input  logic                         clk_sel_wr,
  input  logic                         clk_sel_pll,
  output logic                         clk_busy,
  output logic                         clk_on_pll,
  output logic                         cpu_clk
);
  logic run, fail;
  logic sel_q, en_ref, en_pll;

  boot_copy_fsm #(
    .IMG_WORDS (IMG_WORDS),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .MEM_BASE  (MEM_BASE),
    .TIMEOUT   (TIMEOUT)
  ) u_copy (
    .clk       (clk_ref),
    .rst_n     (rst_n),
    .src_req   (src_req),
    .src_addr  (src_addr),
    .src_ack   (src_ack),
    .src_err   (src_err),
    .src_data  (src_data),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .run       (run),
    .fail      (fail)
  );

  assign bus_own   = ~run;
  assign cpu_rst_n = run;
  assign load_done = run;
  assign load_err  = fail;

  boot_clk_switch #(.SYNC_STAGES(SYNC_STAGES)) u_clksw (
    .clk_ref (clk_ref),
    .pll_clk (pll_clk),
    .rst_n   (rst_n),
    .sel_wr  (clk_sel_wr),
    .sel_pll (clk_sel_pll),
    .busy    (clk_busy),
    .on_pll  (clk_on_pll),
    .cpu_clk (cpu_clk),
    .sel_q   (sel_q),
    .en_ref  (en_ref),
    .en_pll  (en_pll)
  );
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_ref,
  input logic              rst_n,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              bus_own,
  input logic              cpu_rst_n,
  input logic              load_done,
  input logic              load_err,
  input logic              src_req,
  input logic              clk_busy,
  input logic              clk_sel_wr,
  input logic              sel_q,
  input logic              en_ref,
  input logic              en_pll
);
  // R2: memory writes happen only while the loader owns the bus
  p_we_owned_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    mem_we |-> bus_own);

  // R2: back-to-back writes go to consecutive addresses
  p_addr_step_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

  // R4: released state is held, processor out of reset, bus free
  p_done_hold_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    load_done |=> (load_done && cpu_rst_n && !bus_own && !mem_we));

  // R5: error state is sticky and keeps the processor in reset
  p_err_hold_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    load_err |=> (load_err && !cpu_rst_n && !src_req && !mem_we));

  // R8: a select write during a switch leaves the selection alone
  p_busy_ignore_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (clk_busy && clk_sel_wr) |=> $stable(sel_q));

  // R9: never both clock enables at once
  p_one_src_r9: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $onehot0({en_ref, en_pll}));
endmodule

bind boot_seq boot_seq_chk #(.ADDR_W(ADDR_W)) u_boot_seq_chk (
  .clk_ref    (clk_ref),
  .rst_n      (rst_n),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .bus_own    (bus_own),
  .cpu_rst_n  (cpu_rst_n),
  .load_done  (load_done),
  .load_err   (load_err),
  .src_req    (src_req),
  .clk_busy   (clk_busy),
  .clk_sel_wr (clk_sel_wr),
  .sel_q      (sel_q),
  .en_ref     (en_ref),
  .en_pll     (en_pll)
);

// File: tb/test_boot_seq.sv
`timescale 1ns/1ps
module test_boot_seq;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 16;
  localparam int IMGW   = 16;
  localparam int TMO    = 24;
  localparam logic [ADDR_W-1:0] BASE = 16'h0100;
  localparam int IDXW   = $clog2(IMGW);

  logic clk_ref = 1'b0;
  logic pll_clk = 1'b0;
  logic rst_n   = 1'b0;
  logic src_req, src_ack, src_err;
  logic [IDXW-1:0] src_addr;
  logic [DATA_W-1:0] src_data;
  logic bus_own, mem_we, cpu_rst_n, load_done, load_err;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic clk_sel_wr, clk_sel_pll, clk_busy, clk_on_pll, cpu_clk;

  int vecs = 0;
  int errs = 0;

  always #2.0 clk_ref = ~clk_ref;          // 250 MHz
  initial begin #0.7; forever #1.5 pll_clk = ~pll_clk; end

  boot_seq #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IMG_WORDS(IMGW),
    .MEM_BASE(BASE), .TIMEOUT(TMO), .SYNC_STAGES(2)
  ) i_boot_seq (
    .clk_ref(clk_ref), .pll_clk(pll_clk), .rst_n(rst_n),
    .src_req(src_req), .src_addr(src_addr), .src_ack(src_ack),
    .src_err(src_err), .src_data(src_data), .bus_own(bus_own),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cpu_rst_n(cpu_rst_n), .load_done(load_done), .load_err(load_err),
    .clk_sel_wr(clk_sel_wr), .clk_sel_pll(clk_sel_pll),
    .clk_busy(clk_busy), .clk_on_pll(clk_on_pll), .cpu_clk(cpu_clk)
  );

  function automatic logic [DATA_W-1:0] img_word(input int i);
    return (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Source model and write monitor
  int  src_mode = 0;     // 0 normal, 1 error at word k, 2 silent from word k
  int  src_k    = 0;
  int  resp_n, wr_n, stall_n, gap_n;
  bit  last_seen;

  function automatic int gap_of(input int i);
    return (i == 5) ? (TMO - 1) : (i % 3);
  endfunction

  always @(negedge clk_ref) begin
    if (!rst_n) begin
      resp_n = 0; wr_n = 0; stall_n = 0; gap_n = 0; last_seen = 0;
      src_ack <= 1'b0; src_err <= 1'b0; src_data <= '0;
    end else begin
      if (last_seen) begin
        chk(cpu_rst_n && !bus_own && load_done, "R4", "release after last write",
            {cpu_rst_n, bus_own, load_done}, 3'b101);
        last_seen = 0;
      end
      if (mem_we) begin
        chk(mem_addr == BASE + ADDR_W'(wr_n), "R2", "write address", mem_addr, BASE + wr_n);
        chk(mem_wdata == img_word(wr_n), "R2", "write data", mem_wdata, img_word(wr_n));
        if (wr_n == IMGW - 1) begin
          chk(!cpu_rst_n && bus_own, "R4", "held during last write",
              {cpu_rst_n, bus_own}, 2'b01);
          last_seen = 1;
        end
        wr_n++;
      end
      src_ack <= 1'b0; src_err <= 1'b0;
      if (src_req) begin
        if (src_mode == 2 && resp_n == src_k) begin
          stall_n++;
        end else if (gap_n < gap_of(resp_n)) begin
          gap_n++;
        end else begin
          chk(src_addr == IDXW'(resp_n), "R3", "request index", src_addr, resp_n);
          src_ack  <= 1'b1;
          src_err  <= (src_mode == 1 && resp_n == src_k);
          src_data <= img_word(resp_n);
          resp_n++;
          gap_n = 0;
        end
      end
    end
  end

  // Clock phase monitor
  bit  arm = 0;
  realtime t_rise = 0.0, t_fall = 0.0;
  int  runts = 0;
  always @(posedge cpu_clk) begin
    if (arm && ($realtime - t_fall) < 1.49) runts++;
    t_rise = $realtime;
  end
  always @(negedge cpu_clk) begin
    if (arm && ($realtime - t_rise) < 1.49) runts++;
    t_fall = $realtime;
  end

  task automatic do_reset(input int mode, input int k);
    rst_n = 1'b0;
    clk_sel_wr = 1'b0; clk_sel_pll = 1'b0;
    src_mode = mode; src_k = k;
    repeat (3) @(negedge clk_ref);
    @(posedge clk_ref); #1;
    rst_n = 1'b1;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_ref);
    #0.5;
  endtask

  task automatic period_ps(output int p);
    realtime a, b;
    @(posedge cpu_clk); a = $realtime;
    @(posedge cpu_clk); b = $realtime;
    p = int'((b - a) * 1000.0);
  endtask

  initial begin
    #400000;
    errs++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int p;
    // ---- Error response (R5) ----
    do_reset(1, 2);
    #0.2;
    chk(bus_own && !cpu_rst_n && !load_done && !load_err, "R1", "reset outputs",
        {bus_own, cpu_rst_n, load_done, load_err}, 4'b1000);
    chk(!clk_busy && !clk_on_pll, "R1", "clock status at reset", {clk_busy, clk_on_pll}, 0);
    arm = 1;
    cyc(30);
    chk(load_err == 1'b1, "R5", "error flag", load_err, 1);
    chk(!cpu_rst_n && bus_own && !load_done, "R5", "processor held",
        {cpu_rst_n, bus_own, load_done}, 3'b010);
    chk(wr_n == 2, "R5", "words written before error", wr_n, 2);
    cyc(20);
    chk(!src_req && wr_n == 2 && load_err, "R5", "stays stopped", {src_req, 8'(wr_n)}, 2);

    // ---- Timeout (R6) ----
    arm = 0;
    do_reset(2, 3);
    arm = 1;
    while (stall_n < TMO) cyc(1);
    chk(load_err == 1'b0, "R6", "no error after TIMEOUT-1 silent cycles", load_err, 0);
    cyc(1);
    chk(load_err == 1'b1, "R6", "error after TIMEOUT silent cycles", load_err, 1);
    chk(!cpu_rst_n && wr_n == 3, "R6", "held, three words", {cpu_rst_n, 8'(wr_n)}, 3);

    // ---- Full load with stalls (R2, R3, R4) ----
    arm = 0;
    do_reset(0, 0);
    arm = 1;
    for (int i = 0; i < 400 && !load_done; i++) cyc(1);
    chk(load_done && !load_err, "R3", "load completes despite long gap",
        {load_done, load_err}, 2'b10);
    chk(wr_n == IMGW, "R2", "write count", wr_n, IMGW);
    cyc(10);
    chk(wr_n == IMGW && load_done && cpu_rst_n && !src_req, "R4", "held after load",
        {8'(wr_n), load_done, cpu_rst_n, src_req}, {8'(IMGW), 3'b110});

    // ---- Clock switch (R7, R8, R9, R10) ----
    period_ps(p);
    chk(p == 4000, "R1", "cpu_clk follows reference", p, 4000);
    @(negedge clk_ref); clk_sel_pll = 1'b1; clk_sel_wr = 1'b1;
    @(negedge clk_ref);
    chk(clk_busy == 1'b1, "R7", "busy after select", clk_busy, 1);
    clk_sel_pll = 1'b0;                        // dropped: switch in progress
    @(negedge clk_ref); clk_sel_wr = 1'b0;
    for (int i = 0; i < 50 && clk_busy; i++) cyc(1);
    chk(!clk_busy && clk_on_pll, "R7", "switched to pll", {clk_busy, clk_on_pll}, 1);
    cyc(10);
    chk(clk_on_pll && !clk_busy, "R8", "write during busy ignored",
        {clk_busy, clk_on_pll}, 1);
    period_ps(p);
    chk(p == 3000, "R7", "cpu_clk follows pll", p, 3000);
    @(negedge clk_ref); clk_sel_pll = 1'b0; clk_sel_wr = 1'b1;
    @(negedge clk_ref); clk_sel_wr = 1'b0;
    for (int i = 0; i < 50 && clk_busy; i++) cyc(1);
    chk(!clk_busy && !clk_on_pll, "R10", "back on reference", {clk_busy, clk_on_pll}, 0);
    period_ps(p);
    chk(p == 4000, "R10", "cpu_clk follows reference again", p, 4000);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk_ref); clk_sel_pll = 1'b1; clk_sel_wr = 1'b1;
      @(negedge clk_ref); clk_sel_wr = 1'b0;
      for (int i = 0; i < 50 && clk_busy; i++) cyc(1);
      @(negedge clk_ref); clk_sel_pll = 1'b0; clk_sel_wr = 1'b1;
      @(negedge clk_ref); clk_sel_wr = 1'b0;
      for (int i = 0; i < 50 && clk_busy; i++) cyc(1);
    end
    cyc(5);
    chk(runts == 0, "R9", "short cpu_clk phases", runts, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule